// File: doc/BRIEF.md
# Two-Slot Execution List Scheduler

This block follows GPU context execution across two submission slots. Each slot holds a pair of 64-bit context descriptors. A schedule-in request delivers a new pair. A schedule-out request names the context that has just finished. From these requests the block tracks three things: which slot is running, whether the other slot is waiting as a pending list, and which element (0 or 1) of the running pair is live. A 64-bit execution status word follows this state continuously.

Every transition produces a context-status event for a downstream status buffer writer. An event carries a 16-bit reason code and a 32-bit context ID. Its hold-interrupt flag tells the writer not to raise an interrupt yet, because a second event is coming.

The transitions handled are:
- start from idle;
- lite-restore preemption, where the new pair resumes the live context;
- plain queueing of a pending list;
- an element switch inside a pair;
- retirement of the last element, either going idle or promoting the pending list.

In the promotion case the block emits two events on consecutive cycles. It moves through three named states: `ST_IDLE` (nothing runs), `ST_ACTIVE` (a slot runs) and `ST_TAIL` (one cycle in which the follow-up event of a promotion is emitted).

The named transitions are:

| Transition | From | To | Cause |
|---|---|---|---|
| start | `ST_IDLE` | `ST_ACTIVE` | schedule-in |
| lite, queue, reject | `ST_ACTIVE` | `ST_ACTIVE` | schedule-in |
| switch | `ST_ACTIVE` | `ST_ACTIVE` | schedule-out of element 0 while element 1 is valid |
| retire | `ST_ACTIVE` | `ST_IDLE` | schedule-out of the last element, no pending list |
| promote | `ST_ACTIVE` | `ST_TAIL` | schedule-out of the last element, pending list present |
| tail | `ST_TAIL` | `ST_ACTIVE` | always, after one cycle |
| error | any non-tail state | same state | a schedule-out that matches nothing |

Top module: `exec_slot_sched`

## Requirements
- R1: After reset, `status_reg` is all zero, `evt_valid`, `sched_in_reject` and `sched_out_error` are 0, and `req_ready` is 1. Both slots are cleared, nothing is running and nothing is pending.
- R2: Descriptor fields are: valid flag at bit 0, 20-bit context address at bits [31:12], context ID at bits [63:32]. Two descriptors are the same context only if both the ID and the address match. Bits [11:1] take no part in the comparison.
- R3: `status_reg` fields are: bit 0 current pointer, bit 1 write pointer, bit 2 queue full, bit 3 list 1 valid, bit 4 list 0 valid, bit 17 list 1 active, bit 18 list 0 active, bits [63:32] ID of the running context. While slot N runs, the current pointer is N, the write pointer is not N, and only list N has its valid and active bits set. Queue full is 1 exactly when a pending list exists. While nothing runs, bits [63:32] and the four valid/active bits are 0, and both pointers keep their last values.
- R4: A schedule-in while idle stores the pair into the slot selected by the write pointer and makes it the running slot at element 0. It emits event code 0x0001 (bit 0, idle-to-active) with ID 0 and the hold flag at 0.
- R5: A schedule-in while queue full is set pulses `sched_in_reject` for one cycle. It changes no state and emits no event.
- R6: Lite-restore applies to a schedule-in while running when either of two conditions holds: running element 1 is valid, is the same context as the new element 0, and element 1 is live; or running element 1 is invalid and running element 0 is the same context as the new element 0. The new slot then becomes running at element 0, and the block emits code 0x8002 (bit 15 lite-restore, bit 1 preempted) with the new element 0's ID.
- R7: Any other accepted schedule-in while running stores the pair into the other slot as the pending list, sets queue full and emits no event.
- R8: A schedule-out of live element 0 while element 1 is valid makes element 1 live. It emits code 0x0014 (bit 4 complete, bit 2 element switch) with the retired ID and the hold flag at 0.
- R9: A schedule-out of the last valid element with no pending list leaves nothing running. It emits code 0x0018 (bit 4 complete, bit 3 active-to-idle) with the retired ID and the hold flag at 0.
- R10: A schedule-out of the last valid element with a pending list promotes the pending slot to running at element 0 and clears queue full. It emits code 0x0018 with the retired ID and the hold flag at 1. On the next cycle it emits code 0x0001 with ID 0 and the hold flag at 0. During that next cycle `req_ready` is 0 and requests are ignored.
- R11: A schedule-out whose descriptor is not the live context, or that arrives while nothing runs, pulses `sched_out_error` for one cycle. It changes no state and emits no event.
- R12: When schedule-in and schedule-out are requested in the same cycle, only the schedule-out acts. The schedule-in is ignored and is not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_in_valid | input | 1 | Schedule-in request |
| sched_in_ctx0 | input | 64 | New pair, element 0 descriptor |
| sched_in_ctx1 | input | 64 | New pair, element 1 descriptor |
| sched_out_valid | input | 1 | Schedule-out request |
| sched_out_ctx | input | 64 | Descriptor of the context being retired |
| req_ready | output | 1 | Low in the cycle that emits a follow-up event, when requests are ignored |
| status_reg | output | 64 | Execution status word |
| evt_valid | output | 1 | Context-status event present |
| evt_code | output | 16 | Event reason bits |
| evt_id | output | 32 | Event context ID |
| evt_hold_irq | output | 1 | Interrupt held back because another event follows |
| sched_in_reject | output | 1 | Schedule-in refused because queue full is set |
| sched_out_error | output | 1 | Schedule-out did not match the live context |

## Verification
Running, pending and the live element are all internal, but each one shows at the ports. A wrong running slot or live element shows in `status_reg` at the next clock edge, as wrong pointer bits, wrong valid/active bits or a wrong context ID. It also causes later schedule-out requests to be flagged as errors, or to produce the wrong event code. A lost pending flag shows at once in the queue-full bit. It also turns a later promotion (hold flag 1, then follow-up event) into a plain active-to-idle. The stimulus therefore crosses every transition and checks both the status word and the event stream after each request.

// File: rtl/exec_sched_pkg.sv
package exec_sched_pkg;

    localparam int DESC_W   = 64;
    localparam int ID_W     = 32;
    localparam int ID_LSB   = 32;
    localparam int ADDR_W   = 20;
    localparam int ADDR_LSB = 12;
    localparam int STAT_W   = 64;
    localparam int CODE_W   = 16;
    localparam int NSLOT    = 2;

    // event reason bits, decoded by the status buffer writer
    localparam logic [CODE_W-1:0] EV_I2A     = 16'h0001;
    localparam logic [CODE_W-1:0] EV_PREEMPT = 16'h0002;
    localparam logic [CODE_W-1:0] EV_ESWITCH = 16'h0004;
    localparam logic [CODE_W-1:0] EV_A2I     = 16'h0008;
    localparam logic [CODE_W-1:0] EV_DONE    = 16'h0010;
    localparam logic [CODE_W-1:0] EV_LITE    = 16'h8000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_TAIL   = 2'd2
    } sched_state_e;

    function automatic logic desc_ok(input logic [DESC_W-1:0] d);
        return d[0];
    endfunction

    function automatic logic [ID_W-1:0] desc_id(input logic [DESC_W-1:0] d);
        return d[ID_LSB +: ID_W];
    endfunction

    function automatic logic same_ctx(input logic [DESC_W-1:0] a,
                                      input logic [DESC_W-1:0] b);
        return (a[ID_LSB +: ID_W] == b[ID_LSB +: ID_W]) &&
               (a[ADDR_LSB +: ADDR_W] == b[ADDR_LSB +: ADDR_W]);
    endfunction

endpackage

// File: rtl/exec_slot_store.sv
module exec_slot_store
    import exec_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_idx,
    input  logic [DESC_W-1:0] wr_ctx0,
    input  logic [DESC_W-1:0] wr_ctx1,
    input  logic              rd_idx,
    output logic [DESC_W-1:0] rd_ctx0,
    output logic [DESC_W-1:0] rd_ctx1
);

    logic [DESC_W-1:0] e0_q [NSLOT];
    logic [DESC_W-1:0] e1_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e0_q[s] <= '0;
                e1_q[s] <= '0;
            end else if (wr_en && (wr_idx == s[0])) begin
                e0_q[s] <= wr_ctx0;
                e1_q[s] <= wr_ctx1;
            end
        end
    end

    assign rd_ctx0 = e0_q[rd_idx];
    assign rd_ctx1 = e1_q[rd_idx];

endmodule

// File: rtl/exec_status_encode.sv
module exec_status_encode
    import exec_sched_pkg::*;
(
    input  logic            run_valid,
    input  logic            run_idx,
    input  logic            cur_ptr,
    input  logic            wr_ptr,
    input  logic            pend_valid,
    input  logic [ID_W-1:0] run_id,
    output logic [STAT_W-1:0] status
);

    logic list1_on;
    logic list0_on;

    assign list1_on = run_valid &&  run_idx;
    assign list0_on = run_valid && !run_idx;

    always_comb begin
        status          = '0;
        status[0]       = cur_ptr;
        status[1]       = wr_ptr;
        status[2]       = pend_valid;
        status[3]       = list1_on;
        status[4]       = list0_on;
        status[17]      = list1_on;
        status[18]      = list0_on;
        status[63:32]   = run_valid ? run_id : '0;
    end

endmodule

// File: rtl/exec_slot_sched.sv
module exec_slot_sched
    import exec_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_in_valid,
    input  logic [DESC_W-1:0] sched_in_ctx0,
    input  logic [DESC_W-1:0] sched_in_ctx1,
    input  logic              sched_out_valid,
    input  logic [DESC_W-1:0] sched_out_ctx,
    output logic              req_ready,
    output logic [STAT_W-1:0] status_reg,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code,
    output logic [ID_W-1:0]   evt_id,
    output logic              evt_hold_irq,
    output logic              sched_in_reject,
    output logic              sched_out_error
);

    sched_state_e state_q, state_d;
    logic run_idx_q, run_idx_d;
    logic elem_q, elem_d;
    logic pend_q, pend_d;
    logic cur_q, cur_d;
    logic wp_q, wp_d;

    logic              wr_en;
    logic [DESC_W-1:0] run_c0, run_c1, live_desc;
    logic              lite_hit;

    logic              ev_v_d, hold_d, rej_d, err_d;
    logic [CODE_W-1:0] code_d;
    logic [ID_W-1:0]   id_d;

    exec_slot_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wp_q),
        .wr_ctx0 (sched_in_ctx0),
        .wr_ctx1 (sched_in_ctx1),
        .rd_idx  (run_idx_q),
        .rd_ctx0 (run_c0),
        .rd_ctx1 (run_c1)
    );

    assign live_desc = elem_q ? run_c1 : run_c0;

    exec_status_encode u_enc (
        .run_valid  (state_q != ST_IDLE),
        .run_idx    (run_idx_q),
        .cur_ptr    (cur_q),
        .wr_ptr     (wp_q),
        .pend_valid (pend_q),
        .run_id     (desc_id(live_desc)),
        .status     (status_reg)
    );

    assign lite_hit = (desc_ok(run_c1) && same_ctx(run_c1, sched_in_ctx0) && elem_q) ||
                      (!desc_ok(run_c1) && same_ctx(run_c0, sched_in_ctx0));

    always_comb begin
        state_d   = state_q;
        run_idx_d = run_idx_q;
        elem_d    = elem_q;
        pend_d    = pend_q;
        cur_d     = cur_q;
        wp_d      = wp_q;
        wr_en     = 1'b0;
        ev_v_d    = 1'b0;
        code_d    = '0;
        id_d      = '0;
        hold_d    = 1'b0;
        rej_d     = 1'b0;
        err_d     = 1'b0;
        unique case (state_q)
            ST_TAIL: begin
                ev_v_d  = 1'b1;
                code_d  = EV_I2A;
                state_d = ST_ACTIVE;
            end
            ST_IDLE, ST_ACTIVE: begin
                if (sched_out_valid) begin
                    if ((state_q == ST_IDLE) || !same_ctx(sched_out_ctx, live_desc)) begin
                        err_d = 1'b1;
                    end else if (!elem_q && desc_ok(run_c1)) begin
                        elem_d = 1'b1;
                        ev_v_d = 1'b1;
                        code_d = EV_DONE | EV_ESWITCH;
                        id_d   = desc_id(sched_out_ctx);
                    end else begin
                        ev_v_d = 1'b1;
                        code_d = EV_DONE | EV_A2I;
                        id_d   = desc_id(sched_out_ctx);
                        elem_d = 1'b0;
                        if (pend_q) begin
                            hold_d    = 1'b1;
                            run_idx_d = !run_idx_q;
                            cur_d     = !run_idx_q;
                            wp_d      = run_idx_q;
                            pend_d    = 1'b0;
                            state_d   = ST_TAIL;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end else if (sched_in_valid) begin
                    if (pend_q) begin
                        rej_d = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                        if ((state_q == ST_IDLE) || lite_hit) begin
                            run_idx_d = wp_q;
                            cur_d     = wp_q;
                            wp_d      = !wp_q;
                            elem_d    = 1'b0;
                            ev_v_d    = 1'b1;
                            state_d   = ST_ACTIVE;
                            if (state_q == ST_IDLE) begin
                                code_d = EV_I2A;
                            end else begin
                                code_d = EV_LITE | EV_PREEMPT;
                                id_d   = desc_id(sched_in_ctx0);
                            end
                        end else begin
                            pend_d = 1'b1;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            run_idx_q <= 1'b0;
            elem_q    <= 1'b0;
            pend_q    <= 1'b0;
            cur_q     <= 1'b0;
            wp_q      <= 1'b0;
        end else begin
            state_q   <= state_d;
            run_idx_q <= run_idx_d;
            elem_q    <= elem_d;
            pend_q    <= pend_d;
            cur_q     <= cur_d;
            wp_q      <= wp_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid       <= 1'b0;
            evt_code        <= '0;
            evt_id          <= '0;
            evt_hold_irq    <= 1'b0;
            sched_in_reject <= 1'b0;
            sched_out_error <= 1'b0;
        end else begin
            evt_valid       <= ev_v_d;
            evt_code        <= code_d;
            evt_id          <= id_d;
            evt_hold_irq    <= hold_d;
            sched_in_reject <= rej_d;
            sched_out_error <= err_d;
        end
    end

    assign req_ready = (state_q != ST_TAIL);

endmodule

// File: rtl/exec_slot_sched_checker.sv
module exec_slot_sched_checker
    import exec_sched_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sched_in_valid,
    input logic              sched_out_valid,
    input logic              req_ready,
    input logic [STAT_W-1:0] status_reg,
    input logic              evt_valid,
    input logic [CODE_W-1:0] evt_code,
    input logic [ID_W-1:0]   evt_id,
    input logic              evt_hold_irq,
    input logic              sched_in_reject,
    input logic              sched_out_error
);

    AST_ONE_LIST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_reg[17], status_reg[18]}) &&
        (status_reg[17] == status_reg[3]) && (status_reg[18] == status_reg[4])); // R3

    AST_IDLE_NO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_reg[3] && !status_reg[4]) |-> (status_reg[63:32] == '0)); // R3

    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_in_valid && !sched_out_valid && req_ready && status_reg[2])
        |=> (sched_in_reject && !evt_valid && (status_reg == $past(status_reg)))); // R5

    AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_hold_irq)
        |=> (evt_valid && (evt_code == EV_I2A) && (evt_id == '0) && !evt_hold_irq)); // R10

    AST_NOT_READY_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (evt_valid && evt_hold_irq)); // R10

    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sched_out_error |-> (!evt_valid && $stable(status_reg))); // R11

endmodule

bind exec_slot_sched exec_slot_sched_checker u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .sched_in_valid  (sched_in_valid),
    .sched_out_valid (sched_out_valid),
    .req_ready       (req_ready),
    .status_reg      (status_reg),
    .evt_valid       (evt_valid),
    .evt_code        (evt_code),
    .evt_id          (evt_id),
    .evt_hold_irq    (evt_hold_irq),
    .sched_in_reject (sched_in_reject),
    .sched_out_error (sched_out_error)
);

// File: tb/exec_slot_sched_bench.sv
`timescale 1ns/1ps
module exec_slot_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_in_valid = 1'b0;
    logic [63:0] sched_in_ctx0 = '0;
    logic [63:0] sched_in_ctx1 = '0;
    logic        sched_out_valid = 1'b0;
    logic [63:0] sched_out_ctx = '0;
    logic        req_ready;
    logic [63:0] status_reg;
    logic        evt_valid;
    logic [15:0] evt_code;
    logic [31:0] evt_id;
    logic        evt_hold_irq;
    logic        sched_in_reject;
    logic        sched_out_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [48:0] expq [$];   // {code, id, hold}

    always #2.5 clk = ~clk;

    exec_slot_sched u_exec_slot_sched (
        .clk(clk), .rst_n(rst_n),
        .sched_in_valid(sched_in_valid), .sched_in_ctx0(sched_in_ctx0),
        .sched_in_ctx1(sched_in_ctx1), .sched_out_valid(sched_out_valid),
        .sched_out_ctx(sched_out_ctx), .req_ready(req_ready),
        .status_reg(status_reg), .evt_valid(evt_valid), .evt_code(evt_code),
        .evt_id(evt_id), .evt_hold_irq(evt_hold_irq),
        .sched_in_reject(sched_in_reject), .sched_out_error(sched_out_error)
    );

    function automatic logic [63:0] mk(input logic [31:0] id, input logic [19:0] addr,
                                       input logic v, input logic [10:0] misc);
        return {id, addr, misc, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic expect_ev(input logic [15:0] code, input logic [31:0] id, input logic hold);
        expq.push_back({code, id, hold});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_in(input logic [63:0] c0, input logic [63:0] c1);
        sched_in_valid = 1'b1; sched_in_ctx0 = c0; sched_in_ctx1 = c1;
        tick();
        sched_in_valid = 1'b0;
    endtask

    task automatic do_out(input logic [63:0] d);
        sched_out_valid = 1'b1; sched_out_ctx = d;
        tick();
        sched_out_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && evt_valid && !done) begin
            if (expq.size() == 0) begin
                chk("R4 unexpected event", {evt_code, evt_id, 15'd0, evt_hold_irq}, 64'd0);
            end else begin
                logic [48:0] e;
                e = expq.pop_front();
                chk("R8 event stream", {15'd0, evt_code, evt_id, evt_hold_irq}, {15'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] ca, cb, cc, cd, cf, cg, ch, inv;
        ca  = mk(32'd1, 20'h00100, 1'b1, 11'h0);
        cb  = mk(32'd2, 20'h00200, 1'b1, 11'h0);
        cc  = mk(32'd3, 20'h00300, 1'b1, 11'h0);
        cd  = mk(32'd0, 20'h0,     1'b0, 11'h0);
        cf  = mk(32'd6, 20'h00600, 1'b1, 11'h0);
        cg  = mk(32'd7, 20'h00700, 1'b1, 11'h0);
        ch  = mk(32'd8, 20'h00800, 1'b1, 11'h0);
        inv = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status_reg, 64'h0);
        chk("R1 outputs", {61'd0, evt_valid, sched_in_reject, sched_out_error}, 64'h0);
        chk("R1 ready", {63'd0, req_ready}, 64'd1);

        // R11 schedule-out while idle
        do_out(ca);
        chk("R11 idle error", {63'd0, sched_out_error}, 64'd1);
        chk("R11 idle status", status_reg, 64'h0);

        // R4 start from idle into slot 0
        expect_ev(16'h0001, 32'd0, 1'b0);
        do_in(ca, cb);
        chk("R4 R3 status slot0", status_reg, 64'h00000001_00040012);

        // R11 mismatching descriptor
        do_out(mk(32'd9, 20'h00100, 1'b1, 11'h0));
        chk("R11 mismatch error", {63'd0, sched_out_error}, 64'd1);
        chk("R11 mismatch status", status_reg, 64'h00000001_00040012);

        // R8 element switch, R2 misc bits ignored
        expect_ev(16'h0014, 32'd1, 1'b0);
        do_out(mk(32'd1, 20'h00100, 1'b1, 11'h7f0));
        chk("R8 R2 no error", {63'd0, sched_out_error}, 64'd0);
        chk("R8 status elem1", status_reg, 64'h00000002_00040012);

        // R7 pending list
        do_in(cc, cd);
        chk("R7 queue full", status_reg, 64'h00000002_00040016);

        // R5 reject while full
        do_in(cf, cg);
        chk("R5 reject", {63'd0, sched_in_reject}, 64'd1);
        chk("R5 status unchanged", status_reg, 64'h00000002_00040016);

        // R10 last element with pending list
        expect_ev(16'h0018, 32'd2, 1'b1);
        expect_ev(16'h0001, 32'd0, 1'b0);
        do_out(cb);
        chk("R10 ready low", {63'd0, req_ready}, 64'd0);
        sched_in_valid = 1'b1; sched_in_ctx0 = cf; sched_in_ctx1 = cg;
        tick();
        sched_in_valid = 1'b0;
        chk("R10 ready back", {63'd0, req_ready}, 64'd1);
        chk("R10 ignored no reject", {63'd0, sched_in_reject}, 64'd0);
        chk("R10 promoted status", status_reg, 64'h00000003_00020009);

        // R6 lite-restore, element 1 invalid, R2 misc bits ignored
        expect_ev(16'h8002, 32'd3, 1'b0);
        do_in(mk(32'd3, 20'h00300, 1'b1, 11'h155), cf);
        chk("R6 lite b status", status_reg, 64'h00000003_00040012);

        // R8 then R6 lite-restore with element 1 live
        expect_ev(16'h0014, 32'd3, 1'b0);
        do_out(cc);
        chk("R8 status to F", status_reg, 64'h00000006_00040012);
        expect_ev(16'h8002, 32'd6, 1'b0);
        do_in(cf, cg);
        chk("R6 lite a status", status_reg, 64'h00000006_00020009);

        // R7 element 1 matches but element 0 still live
        do_in(cg, ch);
        chk("R7 pending not lite", status_reg, 64'h00000006_0002000D);

        // R12 simultaneous requests
        expect_ev(16'h0014, 32'd6, 1'b0);
        sched_in_valid = 1'b1; sched_in_ctx0 = ca; sched_in_ctx1 = cb;
        do_out(cf);
        sched_in_valid = 1'b0;
        chk("R12 no reject", {63'd0, sched_in_reject}, 64'd0);
        chk("R12 status", status_reg, 64'h00000007_0002000D);

        // R10 second promotion
        expect_ev(16'h0018, 32'd7, 1'b1);
        expect_ev(16'h0001, 32'd0, 1'b0);
        do_out(cg);
        tick();
        chk("R10 promoted slot0", status_reg, 64'h00000007_00040012);

        // R9 retire to idle, pointers held
        expect_ev(16'h0014, 32'd7, 1'b0);
        do_out(cg);
        expect_ev(16'h0018, 32'd8, 1'b0);
        do_out(ch);
        chk("R9 R3 idle status", status_reg, 64'h00000000_00000002);

        // R4 start into slot 1, then R9
        expect_ev(16'h0001, 32'd0, 1'b0);
        do_in(ca, inv);
        chk("R4 slot1 status", status_reg, 64'h00000001_00020009);
        expect_ev(16'h0018, 32'd1, 1'b0);
        do_out(ca);
        chk("R9 idle from slot1", status_reg, 64'h00000000_00000001);

        tick();
        chk("R8 queue drained", {32'd0, 32'(expq.size())}, 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule